// File: doc/BRIEF.md
# Auto-reload overflow interval timer

This block is a 32-bit up-counting interval timer behind a plain register port. Software sets the starting count and a reload value, then turns on a run bit and, optionally, a reload bit. When the count rolls over from all-ones, a sticky overflow flag is raised. With reload on, the count restarts from the reload value, which gives a periodic event. With reload off, the timer stops after the first rollover. An interval of N+1 clocks is programmed by writing all-ones minus N.

Writes to the control, reload and count registers are posted. The bus side captures each write in a single cycle. The write reaches the counting logic a fixed number of clocks later, set by `SYNC_LAT` (default 3), so that the delay of a clock-domain resynchroniser is modelled. While a posted write is still in flight, a per-register pending bit is high. A further write to that same register is held off with `wrWait` until the bit drops. The status and interrupt-enable registers act immediately.

Top module: `ovf_timer`

## Requirements
- R1: Register map, by `wrAddr`/`rdAddr`: 0 control (bit0 run, bit1 reload), 1 reload value, 2 count, 3 status (bit0 overflow flag), 4 interrupt enable (bit0), 5 pending (bit0 control, bit1 reload value, bit2 count). After reset every register reads 0 and `irq` is 0.
- R2: With run and reload set and the reload value at all-ones minus N, the overflow flag is raised once every N+1 clocks.
- R3: With reload clear, the rollover from all-ones clears the run bit, and the count then stays at 0.
- R4: An overflow sets the status flag. Writing 1 to status bit0 clears it, and writing 0 leaves it unchanged. `irq` equals the flag ANDed with interrupt-enable bit0.
- R5: A write accepted at a clock edge to address 0, 1 or 2 changes that register exactly `SYNC_LAT` edges later. Its pending bit reads 1 from the edge after acceptance until that same later edge.
- R6: A write to address 0, 1 or 2 whose pending bit is set raises `wrWait` and is not taken. It is taken at the first edge after the pending bit clears.
- R7: Clearing the run bit freezes the count and leaves a set overflow flag unchanged.
- R8: With a reload value of 0 and reload on, the count reads as a free-running counter that wraps from all-ones to 0 and keeps counting.

Only addresses 0 to 2 are posted. Writes to status and interrupt enable take effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request, held until `wrWait` is low |
| wrAddr | input | 3 | Write register address |
| wrData | input | 32 | Write data |
| wrWait | output | 1 | Write held off; the posted register is busy |
| rdAddr | input | 3 | Read register address |
| rdData | output | 32 | Read data, combinational from `rdAddr` |
| irq | output | 1 | Overflow interrupt |

## Verification
If the posted pipeline holds a wrong pending state, the pending register shows it the cycle after the write. A lost or doubled write shows as a reload value or count that differs from the expected value `SYNC_LAT` edges later. A wrong reload, rollover or one-shot stop decision changes the spacing of `irq` edges, so the bench measures that spacing to the exact clock and does not just test for some edge. A frozen or running count after a stop is caught by two reads a few cycles apart. The free-running check reads the count on the exact cycles around the rollover.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;
  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_LOAD  = 3'd1;
  localparam logic [2:0] ADDR_COUNT = 3'd2;
  localparam logic [2:0] ADDR_STAT  = 3'd3;
  localparam logic [2:0] ADDR_IRQEN = 3'd4;
  localparam logic [2:0] ADDR_PEND  = 3'd5;
  localparam int NUM_POSTED = 3;

  typedef struct packed {
    logic applyCtrl;
    logic applyLoad;
    logic applyCount;
    logic runVal;
    logic autoVal;
  } tmrStrobe_t;

  function automatic logic [2:0] postedAddr(input int idx);
    case (idx)
      0:       return ADDR_CTRL;
      1:       return ADDR_LOAD;
      default: return ADDR_COUNT;
    endcase
  endfunction
endpackage

// File: rtl/ovf_timer_dp.sv
module ovf_timer_dp
  import ovf_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  tmrStrobe_t   strb,
  input  logic [W-1:0] loadVal,
  input  logic [W-1:0] countVal,
  output logic [W-1:0] countQ,
  output logic [W-1:0] loadQ,
  output logic         runQ,
  output logic         autoQ,
  output logic         ovfPulse
);
  localparam logic [W-1:0] ALL_ONES = '1;

  assign ovfPulse = runQ && (countQ == ALL_ONES);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      loadQ  <= '0;
      runQ   <= 1'b0;
      autoQ  <= 1'b0;
    end else begin
      if (strb.applyLoad) loadQ <= loadVal;

      if (strb.applyCtrl) begin
        runQ  <= strb.runVal;
        autoQ <= strb.autoVal;
      end else if (ovfPulse && !autoQ) begin
        runQ <= 1'b0;
      end

      if (strb.applyCount) begin
        countQ <= countVal;
      end else if (ovfPulse) begin
        countQ <= autoQ ? loadQ : '0;
      end else if (runQ) begin
        countQ <= countQ + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ovf_timer_ctrl.sv
module ovf_timer_ctrl
  import ovf_timer_pkg::*;
#(
  parameter int W        = 32,
  parameter int SYNC_LAT = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [2:0]   wrAddr,
  input  logic [W-1:0] wrData,
  output logic         wrWait,
  input  logic [2:0]   rdAddr,
  output logic [W-1:0] rdData,
  output logic         irq,
  input  logic         ovfPulse,
  input  logic [W-1:0] countQ,
  input  logic [W-1:0] loadQ,
  input  logic         runQ,
  input  logic         autoQ,
  output tmrStrobe_t   strb,
  output logic [W-1:0] loadVal,
  output logic [W-1:0] countVal,
  output logic [NUM_POSTED-1:0] pendBits,
  output logic         statFlag
);
  localparam int LAST = SYNC_LAT - 1;

  logic [NUM_POSTED-1:0] hitReg;
  logic [NUM_POSTED-1:0] acceptReg;
  logic [NUM_POSTED-1:0] applyReg;
  logic [1:0]            ctrlHold;
  logic                  irqEn;

  for (genvar g = 0; g < NUM_POSTED; g++) begin : gPost
    localparam int HW = (g == 0) ? 2 : W;
    logic [SYNC_LAT-1:0] vld;
    logic [HW-1:0]       holdR;

    assign hitReg[g]    = wrEn && (wrAddr == postedAddr(g));
    assign pendBits[g]  = |vld;
    assign acceptReg[g] = hitReg[g] && !pendBits[g];
    assign applyReg[g]  = vld[LAST];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vld   <= '0;
        holdR <= '0;
      end else begin
        vld <= {vld[SYNC_LAT-2:0], acceptReg[g]};
        if (acceptReg[g]) holdR <= wrData[HW-1:0];
      end
    end

    if (g == 0) begin : gCtrl
      assign ctrlHold = holdR;
    end else if (g == 1) begin : gLoad
      assign loadVal = holdR;
    end else begin : gCount
      assign countVal = holdR;
    end
  end

  assign wrWait = |(hitReg & pendBits);

  assign strb.applyCtrl  = applyReg[0];
  assign strb.applyLoad  = applyReg[1];
  assign strb.applyCount = applyReg[2];
  assign strb.runVal     = ctrlHold[0];
  assign strb.autoVal    = ctrlHold[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statFlag <= 1'b0;
      irqEn    <= 1'b0;
    end else begin
      if (ovfPulse) statFlag <= 1'b1;
      else if (wrEn && wrAddr == ADDR_STAT && wrData[0]) statFlag <= 1'b0;
      if (wrEn && wrAddr == ADDR_IRQEN) irqEn <= wrData[0];
    end
  end

  assign irq = statFlag && irqEn;

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_CTRL:  rdData[1:0] = {autoQ, runQ};
      ADDR_LOAD:  rdData = loadQ;
      ADDR_COUNT: rdData = countQ;
      ADDR_STAT:  rdData[0] = statFlag;
      ADDR_IRQEN: rdData[0] = irqEn;
      ADDR_PEND:  rdData[NUM_POSTED-1:0] = pendBits;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
  import ovf_timer_pkg::*;
#(
  parameter int W        = 32,
  parameter int SYNC_LAT = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [2:0]   wrAddr,
  input  logic [W-1:0] wrData,
  output logic         wrWait,
  input  logic [2:0]   rdAddr,
  output logic [W-1:0] rdData,
  output logic         irq
);
  tmrStrobe_t            strb;
  logic [W-1:0]          loadVal, countVal, countQ, loadQ;
  logic                  runQ, autoQ, ovfPulse, statFlag;
  logic [NUM_POSTED-1:0] pendBits;

  ovf_timer_ctrl #(.W(W), .SYNC_LAT(SYNC_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrWait(wrWait), .rdAddr(rdAddr), .rdData(rdData), .irq(irq),
    .ovfPulse(ovfPulse), .countQ(countQ), .loadQ(loadQ), .runQ(runQ),
    .autoQ(autoQ), .strb(strb), .loadVal(loadVal), .countVal(countVal),
    .pendBits(pendBits), .statFlag(statFlag)
  );

  ovf_timer_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(loadVal),
    .countVal(countVal), .countQ(countQ), .loadQ(loadQ), .runQ(runQ),
    .autoQ(autoQ), .ovfPulse(ovfPulse)
  );
endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk
  import ovf_timer_pkg::*;
#(
  parameter int W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [2:0]            wrAddr,
  input logic                  wrWait,
  input logic                  irq,
  input tmrStrobe_t            strb,
  input logic [W-1:0]          countQ,
  input logic [W-1:0]          loadQ,
  input logic                  runQ,
  input logic                  autoQ,
  input logic                  ovfPulse,
  input logic                  statFlag,
  input logic [NUM_POSTED-1:0] pendBits
);
  // R2: on a periodic rollover the count restarts from the reload value
  a_r2_reload: assert property (@(posedge clk) disable iff (!rstN)
    (ovfPulse && autoQ && !strb.applyCount) |=> (countQ == $past(loadQ)));

  // R3: a one-shot rollover stops the timer
  a_r3_oneshot_stop: assert property (@(posedge clk) disable iff (!rstN)
    (ovfPulse && !autoQ && !strb.applyCtrl) |=> !runQ);

  // R4: the overflow event always leaves the flag set
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> statFlag);

  // R4: no interrupt without the flag
  a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> statFlag);

  // R5: an accepted posted write to the reload register marks it pending
  a_r5_pend_set: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_LOAD && !wrWait) |=> pendBits[1]);

  // R6: a write to a busy register is held off
  a_r6_hold_off: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_COUNT && pendBits[2]) |-> wrWait);

  // R7: a stopped timer keeps its count
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (!runQ && !strb.applyCount) |=> $stable(countQ));
endmodule

bind ovf_timer ovf_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrWait(wrWait),
  .irq(irq), .strb(strb), .countQ(countQ), .loadQ(loadQ), .runQ(runQ),
  .autoQ(autoQ), .ovfPulse(ovfPulse), .statFlag(statFlag), .pendBits(pendBits)
);

// File: tb/ovf_timer_tb.sv
module ovf_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        wrWait;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic rdReq = 1'b0;
  logic finished = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];

  ovf_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrWait(wrWait), .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard items as read results appear
  always @(negedge clk) begin
    if (rdReq) begin
      item_t it;
      it = sbq.pop_front();
      check(rdData == it.exp, it.tag, rdData, it.exp);
    end
  end

  task automatic rdChk(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    rdAddr = a;
    it.exp = e;
    it.tag = tag;
    sbq.push_back(it);
    rdReq = 1'b1;
    @(negedge clk); #1;
    rdReq = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    rdAddr = a;
    @(negedge clk);
    v = rdData;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, output int stalls);
    stalls = 0;
    @(posedge clk); #1;
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    while (wrWait) begin
      stalls++;
      @(negedge clk);
    end
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic wrSettle(input logic [2:0] a, input logic [31:0] d);
    int s;
    wr(a, d, s);
    repeat (4) @(posedge clk);
  endtask

  task automatic waitIrqRise(output int t);
    while (irq) @(negedge clk);
    while (!irq) @(negedge clk);
    t = cyc;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int s, t1, t2;
    logic [31:0] v1, v2;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    rdChk(3'd0, 32'd0, "R1 ctrl");
    rdChk(3'd2, 32'd0, "R1 count");
    rdChk(3'd3, 32'd0, "R1 stat");
    rdChk(3'd5, 32'd0, "R1 pend");
    check(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);

    // R5 posted latency and pending bit
    wr(3'd1, 32'h1234_5678, s);
    rdChk(3'd5, 32'd2, "R5 pend e1");
    rdChk(3'd5, 32'd2, "R5 pend e2");
    rdChk(3'd5, 32'd0, "R5 pend clear");
    rdChk(3'd1, 32'h1234_5678, "R5 load applied");

    // R6 hold-off of a second write to a pending register
    wr(3'd1, 32'hAAAA_0001, s);
    wr(3'd1, 32'hBBBB_0002, s);
    check(s == 2, "R6 stall cycles", s, 32'd2);
    repeat (4) @(posedge clk);
    rdChk(3'd1, 32'hBBBB_0002, "R6 second write lands");

    // R3 one-shot
    wrSettle(3'd2, 32'hFFFF_FFF0);
    wrSettle(3'd0, 32'd1);
    repeat (40) @(posedge clk);
    rdChk(3'd3, 32'd1, "R4 flag set by one-shot");
    rdChk(3'd2, 32'd0, "R3 count stops at 0");
    rdChk(3'd0, 32'd0, "R3 run cleared");
    check(irq == 1'b0, "R4 irq masked", {31'd0, irq}, 32'd0);

    // R4 write-one-to-clear
    wr(3'd3, 32'd0, s);
    rdChk(3'd3, 32'd1, "R4 write 0 ignored");
    wr(3'd3, 32'd1, s);
    rdChk(3'd3, 32'd0, "R4 write 1 clears");

    // R2 periodic interval N+1 with N=9
    wrSettle(3'd1, 32'hFFFF_FFF6);
    wrSettle(3'd2, 32'hFFFF_FFF6);
    wrSettle(3'd4, 32'd1);
    wrSettle(3'd0, 32'd3);
    waitIrqRise(t1);
    wr(3'd3, 32'd1, s);
    waitIrqRise(t2);
    check((t2 - t1) == 10, "R2 period", t2 - t1, 32'd10);
    wr(3'd3, 32'd1, s);
    waitIrqRise(t1);
    check((t1 - t2) == 10, "R2 period again", t1 - t2, 32'd10);
    check(irq == 1'b1, "R4 irq with enable", {31'd0, irq}, 32'd1);

    // R7 stop freezes count, flag kept
    wrSettle(3'd0, 32'd2);
    peek(3'd2, v1);
    repeat (6) @(posedge clk);
    peek(3'd2, v2);
    check(v1 == v2, "R7 count frozen", v2, v1);
    rdChk(3'd3, 32'd1, "R7 flag kept");

    // R8 free-running wrap
    wrSettle(3'd4, 32'd0);
    wr(3'd3, 32'd1, s);
    wrSettle(3'd1, 32'd0);
    wrSettle(3'd2, 32'hFFFF_FFFD);
    wr(3'd0, 32'd3, s);
    repeat (5) @(posedge clk);
    rdChk(3'd2, 32'd0, "R8 wrap to 0");
    rdChk(3'd2, 32'd1, "R8 keeps counting");
    rdChk(3'd3, 32'd1, "R8 flag on wrap");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule